// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block decodes the bus write cycles sent to a parallel NOR flash model that takes its commands as two-cycle unlock sequences. Each write brings a byte address, a data word and a width of 1, 2 or 4 bytes. The sequencer counts the cycles of the current sequence, holds the active command code and reports a read-path mode: array, identification, query or busy. It also applies programs and erases to a small byte-wide storage array and raises a one-cycle request, with its address, for each operation it applies to the array.

Every decision on an address uses a word index. The index is the byte offset inside a sector, shifted right by the bus width. Program can only clear bits. Erase fills either one sector or the whole array with 0xFF. The erase duration is timed outside the block, which reports the end of an erase on `erase_done`. The array can be read at any time through a combinational read port. After any command sequence has started, a counter re-arms a fast array-read indication once enough consecutive idle reads have been seen.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset the mode is array (0), the command code is 0x00, unlock bypass is off, `fast_read` is 1, no request is raised and every storage byte reads 0xFF.
- R2: The word index is the address bits below the sector size, shifted right by 0, 1 or 2 for `wr_size` 0 (1 byte), 1 (2 bytes) or 2 (4 bytes). Unlock and query addresses are matched against this index, never against the raw byte address.
- R3: A normal sequence is 0xAA at index UNLOCK_IDX0 (0x55), then 0x55 at index UNLOCK_IDX1 (0x2A), then a command at UNLOCK_IDX0. Command 0x90 gives mode identification (1), 0xA0 gives mode busy (3), and 0x80 gives mode array. Each is reported on `cmd_code`.
- R4: With 0xA0 latched, the next write ANDs its `wr_size` bytes, little-endian (byte k = data bits 8k+7..8k), into storage at `wr_addr`. It pulses `prog_req` with `prog_addr`, then returns to array mode with command 0x00.
- R5: While `wp` is 1, program and erase leave storage untouched and raise no request, but the command sequence advances exactly as it does with `wp` at 0.
- R6: 0x80, a second unlock pair, then 0x30 at any address erases the sector that holds the address. It pulses `erase_req` with `erase_chip`=0 and the sector base on `erase_addr`, and shows command 0x30 in mode busy. Writes other than 0xF0 during the erase are ignored. `erase_done` returns the block to command 0x00.
- R7: 0x10 as the sixth cycle erases the whole array only at index UNLOCK_IDX0, with `erase_chip`=1. At any other index it aborts to array mode with no erase.
- R8: Command 0x20 enables unlock bypass. After that, commands need no unlock pair and no particular address, and each program returns to command entry. Writing 0x00 in identification mode with bypass on disables bypass.
- R9: Data 0xF0 (low byte) returns the block to array mode with bypass off from any state, except when it is the data of a program, which is stored.
- R10: 0x98 at index 0x55 enters query mode (2, code 0x98), either from idle or from identification mode. Any other write in query mode returns the block to array mode.
- R11: A write that does not fit the current step of a sequence returns the block to idle with command 0x00.
- R12: A write that starts from idle clears `fast_read`. After READ_THRESH (42) consecutive `rd_en` cycles in idle, `fast_read` returns to 1. A non-bypass `erase_done` also sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; the low byte is the command byte |
| wr_size | input | 2 | Width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wp | input | 1 | Write protect for storage updates |
| erase_done | input | 1 | External end-of-erase pulse |
| rd_en | input | 1 | Array read strobe, counted for fast-read re-arm |
| rd_addr | input | ADDR_W | Byte address for the storage read port |
| rd_data | output | 32 | Four bytes from rd_addr, little-endian |
| mode | output | 2 | 0 array, 1 identification, 2 query, 3 busy |
| cmd_code | output | 8 | Active command code |
| fast_read | output | 1 | Fast array-read indication |
| prog_req | output | 1 | One-cycle program applied |
| prog_addr | output | ADDR_W | Address of that program |
| erase_req | output | 1 | One-cycle erase applied |
| erase_chip | output | 1 | Last erase covered the whole array |
| erase_addr | output | ADDR_W | Base address of the erased range |

## Verification
The hardest states to reach are the bypass ones. Bypass is entered only through a full unlock sequence with 0x20, it is invisible on `cmd_code`, and it is seen only through what later writes are allowed to do. The stimulus therefore programs two locations back to back with no unlock pairs and a command at an arbitrary address, then switches off bypass from identification mode and shows that a bare 0xA0 no longer takes effect. The sector-erase case is reached the same way: bytes are programmed in two sectors first, so a single read of each one shows which range the erase covered.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_CMD,
        ST_ARG,
        ST_E_UNL0,
        ST_E_CMD,
        ST_ERASING,
        ST_QUERY
    } seq_st_e;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_QUERY = 2'd2,
        MODE_BUSY  = 2'd3
    } rd_mode_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [7:0] OP_KEY_A     = 8'hAA;
    localparam logic [7:0] OP_KEY_B     = 8'h55;
    localparam logic [7:0] OP_BYPASS    = 8'h20;
    localparam logic [7:0] OP_ERASE_SET = 8'h80;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_PROGRAM   = 8'hA0;
    localparam logic [7:0] OP_CHIP      = 8'h10;
    localparam logic [7:0] OP_SECTOR    = 8'h30;
    localparam logic [7:0] OP_QUERY     = 8'h98;
    localparam logic [7:0] OP_ABORT     = 8'hF0;
    localparam logic [7:0] OP_BYP_EXIT  = 8'h00;

endpackage

// File: rtl/flash_word_index.sv
module flash_word_index #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  idx
);
    import flash_seq_pkg::*;

    logic [IDX_W-1:0] in_sector;

    always_comb begin
        in_sector = addr[IDX_W-1:0];
        case (size)
            SZ_BYTE: idx = in_sector;
            SZ_HALF: idx = in_sector >> 1;
            default: idx = in_sector >> 2;
        endcase
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
    parameter int ADDR_W      = 10,
    parameter int IDX_W       = 9,
    parameter int SECTOR_BYTES = 512,
    parameter int UNLOCK_IDX0 = 'h55,
    parameter int UNLOCK_IDX1 = 'h2A,
    parameter int QUERY_IDX   = 'h55,
    parameter int READ_THRESH = 42,
    localparam int CNT_W      = $clog2(READ_THRESH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wp,
    input  logic              erase_done,
    input  logic              rd_en,
    output logic              prog_fire,
    output logic              erase_fire,
    output logic              chip_fire,
    output logic [ADDR_W-1:0] erase_base,
    output logic [1:0]        mode,
    output logic [7:0]        cmd_code,
    output logic              fast_read,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);
    import flash_seq_pkg::*;

    localparam logic [IDX_W-1:0]  U0   = IDX_W'(UNLOCK_IDX0);
    localparam logic [IDX_W-1:0]  U1   = IDX_W'(UNLOCK_IDX1);
    localparam logic [IDX_W-1:0]  QI   = IDX_W'(QUERY_IDX);
    localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'(SECTOR_BYTES - 1);
    localparam logic [CNT_W-1:0]  THRESH = CNT_W'(READ_THRESH);

    typedef struct packed {
        seq_st_e           st;
        logic              byp;
        logic [7:0]        cmd;
        logic              fast;
        logic [CNT_W-1:0]  cnt;
        logic              prog_req;
        logic [ADDR_W-1:0] prog_addr;
        logic              erase_req;
        logic              erase_chip;
        logic [ADDR_W-1:0] erase_addr;
    } seq_regs_t;

    seq_regs_t q, d;
    logic go_reset, go_bypass, query_hit, key_a_hit, key_b_hit;

    always_comb begin
        d          = q;
        d.prog_req = 1'b0;
        d.erase_req = 1'b0;
        prog_fire  = 1'b0;
        erase_fire = 1'b0;
        chip_fire  = 1'b0;
        erase_base = wr_addr & SECT_MASK;
        go_reset   = 1'b0;
        go_bypass  = 1'b0;
        query_hit  = (idx == QI) && (wr_byte == OP_QUERY);
        key_a_hit  = (idx == U0) && (wr_byte == OP_KEY_A);
        key_b_hit  = (idx == U1) && (wr_byte == OP_KEY_B);

        if (wr_en) begin
            if (q.cmd != OP_PROGRAM && wr_byte == OP_ABORT) begin
                go_reset = 1'b1;
            end else begin
                case (q.st)
                    ST_IDLE: begin
                        d.fast = 1'b0;
                        d.cnt  = '0;
                        if (query_hit) begin
                            d.st  = ST_QUERY;
                            d.cmd = OP_QUERY;
                        end else if (key_a_hit) begin
                            d.st = ST_UNL1;
                        end else begin
                            go_reset = 1'b1;
                        end
                    end
                    ST_UNL1: begin
                        if (key_b_hit) d.st = ST_CMD;
                        else           go_reset = 1'b1;
                    end
                    ST_CMD: begin
                        if (!q.byp && idx != U0) begin
                            go_reset = 1'b1;
                        end else begin
                            case (wr_byte)
                                OP_BYPASS: begin
                                    d.byp     = 1'b1;
                                    go_bypass = 1'b1;
                                end
                                OP_ERASE_SET, OP_IDENT, OP_PROGRAM: begin
                                    d.cmd = wr_byte;
                                    d.st  = ST_ARG;
                                end
                                default: go_reset = 1'b1;
                            endcase
                        end
                    end
                    ST_ARG: begin
                        case (q.cmd)
                            OP_PROGRAM: begin
                                prog_fire   = !wp;
                                d.prog_req  = !wp;
                                d.prog_addr = wr_addr;
                                if (q.byp) go_bypass = 1'b1;
                                else       go_reset  = 1'b1;
                            end
                            OP_ERASE_SET: begin
                                if (query_hit) begin
                                    d.st  = ST_QUERY;
                                    d.cmd = OP_QUERY;
                                end else if (key_a_hit) begin
                                    d.st = ST_E_UNL0;
                                end else begin
                                    go_reset = 1'b1;
                                end
                            end
                            OP_IDENT: begin
                                if (q.byp && wr_byte == OP_BYP_EXIT) begin
                                    go_reset = 1'b1;
                                end else if (query_hit) begin
                                    d.st  = ST_QUERY;
                                    d.cmd = OP_QUERY;
                                end else begin
                                    go_reset = 1'b1;
                                end
                            end
                            default: go_reset = 1'b1;
                        endcase
                    end
                    ST_E_UNL0: begin
                        if (key_b_hit) d.st = ST_E_CMD;
                        else           go_reset = 1'b1;
                    end
                    ST_E_CMD: begin
                        if (wr_byte == OP_CHIP && idx == U0) begin
                            d.st         = ST_ERASING;
                            d.cmd        = OP_CHIP;
                            erase_fire   = !wp;
                            chip_fire    = 1'b1;
                            d.erase_req  = !wp;
                            d.erase_chip = 1'b1;
                            d.erase_addr = '0;
                        end else if (wr_byte == OP_SECTOR) begin
                            d.st         = ST_ERASING;
                            d.cmd        = OP_SECTOR;
                            erase_fire   = !wp;
                            d.erase_req  = !wp;
                            d.erase_chip = 1'b0;
                            d.erase_addr = erase_base;
                        end else begin
                            go_reset = 1'b1;
                        end
                    end
                    ST_ERASING: begin
                        d = d;
                    end
                    default: go_reset = 1'b1;
                endcase
            end
        end else if (erase_done && q.st == ST_ERASING) begin
            d.cmd = 8'h00;
            if (q.byp) begin
                d.st = ST_CMD;
            end else begin
                d.st   = ST_IDLE;
                d.fast = 1'b1;
            end
        end else if (rd_en && q.st == ST_IDLE && !q.fast) begin
            d.cnt = q.cnt + 1'b1;
            if (d.cnt == THRESH) d.fast = 1'b1;
        end

        if (go_reset) begin
            d.st  = ST_IDLE;
            d.byp = 1'b0;
            d.cmd = 8'h00;
        end
        if (go_bypass) begin
            d.st  = ST_CMD;
            d.cmd = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st         <= ST_IDLE;
            q.byp        <= 1'b0;
            q.cmd        <= 8'h00;
            q.fast       <= 1'b1;
            q.cnt        <= '0;
            q.prog_req   <= 1'b0;
            q.prog_addr  <= '0;
            q.erase_req  <= 1'b0;
            q.erase_chip <= 1'b0;
            q.erase_addr <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.cmd)
            OP_IDENT:                       mode = MODE_IDENT;
            OP_QUERY:                       mode = MODE_QUERY;
            OP_PROGRAM, OP_CHIP, OP_SECTOR: mode = MODE_BUSY;
            default:                        mode = MODE_ARRAY;
        endcase
    end

    assign cmd_code   = q.cmd;
    assign fast_read  = q.fast;
    assign prog_req   = q.prog_req;
    assign prog_addr  = q.prog_addr;
    assign erase_req  = q.erase_req;
    assign erase_chip = q.erase_chip;
    assign erase_addr = q.erase_addr;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte == OP_ABORT && q.cmd != OP_PROGRAM)
        |=> (q.st == ST_IDLE && !q.byp && q.cmd == 8'h00)); // R9

    AST_ERASE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ERASING && wr_en && wr_byte != OP_ABORT)
        |=> (q.st == ST_ERASING && $stable(q.cmd))); // R6

    AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_QUERY && wr_en) |=> (q.st == ST_IDLE)); // R10

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && wr_en && wr_byte != OP_ABORT) |=> !q.fast); // R12

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.prog_req |=> !q.prog_req); // R4
endmodule

// File: rtl/flash_byte_store.sv
module flash_byte_store #(
    parameter int ARRAY_BYTES  = 1024,
    parameter int SECTOR_BYTES = 512,
    localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [31:0]       prog_data,
    input  logic [1:0]        prog_size,
    input  logic              erase_en,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] erase_base,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    import flash_seq_pkg::*;

    localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'(SECTOR_BYTES - 1);

    logic [7:0] mem_q [ARRAY_BYTES];
    logic [7:0] mem_d [ARRAY_BYTES];
    int         nbytes;

    always_comb begin
        case (prog_size)
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = 4;
        endcase
        for (int i = 0; i < ARRAY_BYTES; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && (erase_all || ((ADDR_W'(i) & SECT_MASK) == erase_base)))
                mem_d[i] = 8'hFF;
        end
        if (prog_en) begin
            for (int k = 0; k < 4; k++) begin
                if (k < nbytes)
                    mem_d[prog_addr + ADDR_W'(k)] =
                        mem_q[prog_addr + ADDR_W'(k)] & prog_data[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ARRAY_BYTES; i++) begin
            if (!rst_n) mem_q[i] <= 8'hFF;
            else        mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++)
            rd_data[8*k +: 8] = mem_q[rd_addr + ADDR_W'(k)];
    end

    AST_PROG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en)
        |=> ((mem_q[$past(prog_addr)] & ~$past(mem_q[prog_addr])) == 8'h00)); // R4
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int SECTOR_BYTES = 512,
    parameter int SECTORS      = 2,
    parameter int UNLOCK_IDX0  = 'h55,
    parameter int UNLOCK_IDX1  = 'h2A,
    parameter int QUERY_IDX    = 'h55,
    parameter int READ_THRESH  = 42,
    localparam int ARRAY_BYTES = SECTOR_BYTES * SECTORS,
    localparam int ADDR_W      = $clog2(ARRAY_BYTES),
    localparam int IDX_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        wr_size,
    input  logic              wp,
    input  logic              erase_done,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [1:0]        mode,
    output logic [7:0]        cmd_code,
    output logic              fast_read,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);
    logic [IDX_W-1:0]  idx;
    logic              prog_fire, erase_fire, chip_fire;
    logic [ADDR_W-1:0] erase_base;

    flash_word_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
        .addr (wr_addr),
        .size (wr_size),
        .idx  (idx)
    );

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SECTOR_BYTES(SECTOR_BYTES),
        .UNLOCK_IDX0(UNLOCK_IDX0), .UNLOCK_IDX1(UNLOCK_IDX1),
        .QUERY_IDX(QUERY_IDX), .READ_THRESH(READ_THRESH)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_byte    (wr_data[7:0]),
        .idx        (idx),
        .wp         (wp),
        .erase_done (erase_done),
        .rd_en      (rd_en),
        .prog_fire  (prog_fire),
        .erase_fire (erase_fire),
        .chip_fire  (chip_fire),
        .erase_base (erase_base),
        .mode       (mode),
        .cmd_code   (cmd_code),
        .fast_read  (fast_read),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .erase_req  (erase_req),
        .erase_chip (erase_chip),
        .erase_addr (erase_addr)
    );

    flash_byte_store #(.ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_fire),
        .prog_addr  (wr_addr),
        .prog_data  (wr_data),
        .prog_size  (wr_size),
        .erase_en   (erase_fire),
        .erase_all  (chip_fire),
        .erase_base (erase_base),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    wr_size = 2'd0;
    logic          wp = 1'b0;
    logic          erase_done = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [1:0]    mode;
    logic [7:0]    cmd_code;
    logic          fast_read, prog_req, erase_req, erase_chip;
    logic [AW-1:0] prog_addr, erase_addr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    flash_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size), .wp(wp), .erase_done(erase_done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode),
        .cmd_code(cmd_code), .fast_read(fast_read), .prog_req(prog_req),
        .prog_addr(prog_addr), .erase_req(erase_req), .erase_chip(erase_chip),
        .erase_addr(erase_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] dat, input logic [1:0] sz);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = dat;
        wr_size = sz;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    task automatic unlock(input logic [1:0] sz, input logic [7:0] c);
        int sh;
        sh = int'(sz);
        wr('h55 << sh, 32'h0000_00AA, sz);
        wr('h2A << sh, 32'h0000_0055, sz);
        wr('h55 << sh, {24'h0, c}, sz);
    endtask

    task automatic program_byte(input int a, input logic [7:0] v);
        unlock(2'd0, 8'hA0);
        wr(a, {24'h0, v}, 2'd0);
    endtask

    task automatic pulse_done();
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(0, v);
        chk("R1 mode", 32'(mode), 32'd0);
        chk("R1 cmd", 32'(cmd_code), 32'h00);
        chk("R1 fast_read", 32'(fast_read), 32'd1);
        chk("R1 prog_req", 32'(prog_req), 32'd0);
        chk("R1 storage erased", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_program();
        logic [31:0] v;
        unlock(2'd0, 8'hA0);
        chk("R3 program cmd", 32'(cmd_code), 32'hA0);
        chk("R3 program mode busy", 32'(mode), 32'd3);
        wr('h100, 32'h0000_003C, 2'd0);
        peek('h100, v);
        chk("R4 prog_req", 32'(prog_req), 32'd1);
        chk("R4 prog_addr", 32'(prog_addr), 32'h100);
        chk("R4 stored", 32'(v[7:0]), 32'h3C);
        chk("R4 back to array", 32'(cmd_code), 32'h00);
        program_byte('h100, 8'hC3);
        peek('h100, v);
        chk("R4 AND only clears", 32'(v[7:0]), 32'h00);
        unlock(2'd0, 8'h90);
        chk("R3 ident mode", 32'(mode), 32'd1);
        chk("R3 ident cmd", 32'(cmd_code), 32'h90);
        wr(0, 32'h0000_0012, 2'd0);
        chk("R11 write in ident resets", 32'(cmd_code), 32'h00);
    endtask

    task automatic t_width();
        logic [31:0] v;
        unlock(2'd1, 8'hA0);
        chk("R2 half-width unlock", 32'(cmd_code), 32'hA0);
        wr('h10, 32'h0000_1234, 2'd1);
        peek('h10, v);
        chk("R2 half-width program", 32'(v[15:0]), 32'h1234);
        unlock(2'd2, 8'hA0);
        chk("R2 word-width unlock", 32'(cmd_code), 32'hA0);
        wr('h20, 32'h5A5A_0F0F, 2'd2);
        peek('h20, v);
        chk("R2 word-width program", v, 32'h5A5A_0F0F);
        wr('h55, 32'h0000_00AA, 2'd1);
        wr('h54, 32'h0000_0055, 2'd1);
        wr('hAA, 32'h0000_00A0, 2'd1);
        chk("R2 raw byte address rejected", 32'(cmd_code), 32'h00);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        program_byte('h30, 8'hF0);
        peek('h30, v);
        chk("R9 F0 stored as program data", 32'(v[7:0]), 32'hF0);
        unlock(2'd0, 8'h90);
        wr(0, 32'h0000_00F0, 2'd0);
        chk("R9 F0 leaves ident", 32'(cmd_code), 32'h00);
        chk("R9 mode array", 32'(mode), 32'd0);
    endtask

    task automatic t_wp();
        logic [31:0] v;
        wp = 1'b1;
        unlock(2'd0, 8'hA0);
        chk("R5 sequence runs under wp", 32'(cmd_code), 32'hA0);
        wr('h40, 32'h0000_0000, 2'd0);
        peek('h40, v);
        chk("R5 no prog_req", 32'(prog_req), 32'd0);
        chk("R5 storage kept", 32'(v[7:0]), 32'hFF);
        chk("R5 back to array", 32'(cmd_code), 32'h00);
        wp = 1'b0;
    endtask

    task automatic t_query();
        wr('h55, 32'h0000_0098, 2'd0);
        chk("R10 query from idle", 32'(mode), 32'd2);
        chk("R10 query cmd", 32'(cmd_code), 32'h98);
        wr('h3, 32'h0000_0012, 2'd0);
        chk("R10 write leaves query", 32'(cmd_code), 32'h00);
        unlock(2'd0, 8'h90);
        wr('h55, 32'h0000_0098, 2'd0);
        chk("R10 query from ident", 32'(mode), 32'd2);
        wr(0, 32'h0000_0000, 2'd0);
        chk("R10 exit query", 32'(mode), 32'd0);
    endtask

    task automatic t_bad();
        wr('h55, 32'h0000_00AA, 2'd0);
        wr('h10, 32'h0000_0055, 2'd0);
        wr('h55, 32'h0000_0090, 2'd0);
        chk("R11 wrong second address", 32'(cmd_code), 32'h00);
        unlock(2'd0, 8'h77);
        wr('h55, 32'h0000_00A0, 2'd0);
        chk("R11 unknown command resets", 32'(cmd_code), 32'h00);
        wr('h55, 32'h0000_00AA, 2'd0);
        wr('h2A, 32'h0000_0055, 2'd0);
        wr('h12, 32'h0000_0090, 2'd0);
        chk("R11 wrong third address", 32'(cmd_code), 32'h00);
    endtask

    task automatic erase_prefix();
        unlock(2'd0, 8'h80);
        chk("R3 erase setup mode array", 32'(mode), 32'd0);
        wr('h55, 32'h0000_00AA, 2'd0);
        wr('h2A, 32'h0000_0055, 2'd0);
    endtask

    task automatic t_sector();
        logic [31:0] v;
        program_byte('h200, 8'h11);
        erase_prefix();
        wr('h105, 32'h0000_0030, 2'd0);
        chk("R6 erase_req", 32'(erase_req), 32'd1);
        chk("R6 erase_chip low", 32'(erase_chip), 32'd0);
        chk("R6 erase_addr", 32'(erase_addr), 32'h000);
        chk("R6 busy cmd", 32'(cmd_code), 32'h30);
        peek('h100, v);
        chk("R6 sector filled", 32'(v[7:0]), 32'hFF);
        peek('h200, v);
        chk("R6 other sector kept", 32'(v[7:0]), 32'h11);
        wr('h300, 32'h0000_0055, 2'd0);
        chk("R6 write ignored while erasing", 32'(cmd_code), 32'h30);
        pulse_done();
        chk("R6 done returns", 32'(cmd_code), 32'h00);
        chk("R12 done sets fast_read", 32'(fast_read), 32'd1);
    endtask

    task automatic t_chip();
        logic [31:0] v;
        erase_prefix();
        wr('h10, 32'h0000_0010, 2'd0);
        peek('h200, v);
        chk("R7 wrong address aborts", 32'(cmd_code), 32'h00);
        chk("R7 no erase", 32'(erase_req), 32'd0);
        chk("R7 storage kept", 32'(v[7:0]), 32'h11);
        erase_prefix();
        wr('h55, 32'h0000_0010, 2'd0);
        peek('h200, v);
        chk("R7 chip erase flag", 32'(erase_chip), 32'd1);
        chk("R7 chip erase req", 32'(erase_req), 32'd1);
        chk("R7 chip erased", 32'(v[7:0]), 32'hFF);
        chk("R7 busy cmd", 32'(cmd_code), 32'h10);
        pulse_done();
        chk("R7 done returns", 32'(cmd_code), 32'h00);
    endtask

    task automatic t_bypass();
        logic [31:0] v;
        unlock(2'd0, 8'h20);
        chk("R8 bypass idle cmd", 32'(cmd_code), 32'h00);
        wr('h77, 32'h0000_00A0, 2'd0);
        chk("R8 bypass command at any address", 32'(cmd_code), 32'hA0);
        wr('h200, 32'h0000_005A, 2'd0);
        chk("R8 back to command entry", 32'(cmd_code), 32'h00);
        wr('h0, 32'h0000_00A0, 2'd0);
        wr('h201, 32'h0000_0066, 2'd0);
        peek('h200, v);
        chk("R8 two bypass programs", 32'(v[15:0]), 32'h665A);
        wr('h0, 32'h0000_0090, 2'd0);
        chk("R8 ident in bypass", 32'(mode), 32'd1);
        wr('h0, 32'h0000_0000, 2'd0);
        chk("R8 bypass exit", 32'(cmd_code), 32'h00);
        wr('h0, 32'h0000_00A0, 2'd0);
        chk("R8 bypass really off", 32'(cmd_code), 32'h00);
        wr('h202, 32'h0000_0000, 2'd0);
        peek('h202, v);
        chk("R8 no program after exit", 32'(v[7:0]), 32'hFF);
    endtask

    task automatic t_lazy();
        wr('h55, 32'h0000_00AA, 2'd0);
        chk("R12 write clears fast_read", 32'(fast_read), 32'd0);
        wr('h0, 32'h0000_00F0, 2'd0);
        rd_en = 1'b1;
        repeat (41) @(negedge clk);
        rd_en = 1'b0;
        chk("R12 41 reads not enough", 32'(fast_read), 32'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R12 42nd read re-arms", 32'(fast_read), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_width();
        t_abort();
        t_wp();
        t_query();
        t_bad();
        t_sector();
        t_chip();
        t_bypass();
        t_lazy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule